// File: doc/BRIEF.md
# Segmented Waveform Playback Sequencer

The sequencer plays stored I/Q waveforms out of a 1024-word memory. Several segment descriptors are held in the block. Each descriptor gives a first address, a last address, a pacing interval and a 3-bit playback code. A trigger copies the chosen descriptor into an active copy and starts a read-address sequence. There are two kinds of trigger: a rising edge on the update strobe, or a transition of either polarity on the select pin. A down-counting interval timer paces the address. The playback code decides how the address behaves at its limits: it can stop once, stop in a direction set by the pin, bounce between the limits, or wrap back to the start.

Each 32-bit memory word is split into two halves: the upper half drives the I output and the lower half drives the Q output. A sample appears one clock after its address, together with a one-cycle valid pulse. An error flag reports two cases. The first is a playback code that is not defined. The second is a looping code requested while samples are routed to the baseband scaling path.

Top module: `wseq_top`

## Requirements
- R1: While reset is asserted and directly after it, addr_o, i_o, q_o, valid_o and err_o are all zero.
- R2: A trigger loads first address of the descriptor picked by seg_idx_i into addr_o on the next clock edge and clears err_o. A trigger is update_i rising, or any change of sel_pin_i except the resume case of R5.
- R3: After a load, the address moves every P clocks, where P is the captured interval (rate 0 counts as 1). The first move happens P clocks after the load.
- R4: Code 3'b001 (one-shot ramp) raises the address by one per interval. Once the address equals the last address, it stays there.
- R5: Code 3'b010 (pin-steered ramp) counts up toward the last address while sel_pin_i is high and down toward the first address while it is low, and stops at either limit. If this code is active and valid, a sel_pin_i change does not reload the address. It only sets the direction and restarts the interval.
- R6: Code 3'b011 (bouncing ramp) reverses direction at each limit. Starting from the first address, the sequence is first, first+1, …, last, last-1, …, first, first+1, and so on.
- R7: Code 3'b100 (looping ramp) steps up by one and goes from the last address back to the first address.
- R8: Codes 3'b000, 3'b101, 3'b110 and 3'b111 are refused on trigger. err_o rises, addr_o keeps its value and no valid pulse follows.
- R9: While dest_bb_i is 1 at a trigger, codes 3'b011 and 3'b100 are refused as in R8. Codes 3'b001 and 3'b010 still play.
- R10: One clock after every address load or move, valid_o pulses for one cycle. At the same time, i_o shows bits 31:16 and q_o shows bits 15:0 of the word at that address. At other times i_o and q_o hold their values.
- R11: A descriptor write takes effect only at a later trigger. The active sequence keeps the fields that were captured when it started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write enable |
| cfg_idx | input | 2 | Descriptor to write |
| cfg_start | input | 10 | First address for the descriptor |
| cfg_end | input | 10 | Last address for the descriptor |
| cfg_rate | input | 16 | Interval in clocks between moves |
| cfg_mode | input | 3 | Playback code |
| ram_we | input | 1 | Waveform memory write enable |
| ram_waddr | input | 10 | Waveform memory write address |
| ram_wdata | input | 32 | Waveform memory write word |
| seg_idx_i | input | 2 | Descriptor used by the next trigger |
| update_i | input | 1 | Update strobe, acts on its rising edge |
| sel_pin_i | input | 1 | Select pin: every edge triggers; its level sets direction for code 010 |
| dest_bb_i | input | 1 | 1 when samples go to the baseband scaling path |
| addr_o | output | 10 | Current read address |
| i_o | output | 16 | I sample (upper word half) |
| q_o | output | 16 | Q sample (lower word half) |
| valid_o | output | 1 | One-cycle pulse marking new I/Q |
| err_o | output | 1 | Last trigger was refused |

## Verification
The bench uses the default parameters: a 10-bit address, a 16-bit interval, a 32-bit word and four descriptors. It loads every memory word with a distinct value, so any wrong address shows up in the I/Q outputs. Intervals of 0, 1, 2, 3 and 4 with short address ranges let the bench reach every limit case in a few dozen clocks: the end stop, both bounce points, the wrap and the pin-steered stops. The four descriptors let one run switch between all playback codes, refused codes and the baseband destination, and also rewrite a descriptor while it is playing.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] M_RAMP   = 3'd1;
    localparam logic [MODE_W-1:0] M_BIDIR  = 3'd2;
    localparam logic [MODE_W-1:0] M_CBIDIR = 3'd3;
    localparam logic [MODE_W-1:0] M_RECIRC = 3'd4;

    // A code may play when defined and, for looping codes, not aimed at baseband scaling.
    function automatic logic mode_allowed(input logic [MODE_W-1:0] m, input logic to_bb);
        logic defined;
        logic looping;
        defined = (m == M_RAMP) || (m == M_BIDIR) || (m == M_CBIDIR) || (m == M_RECIRC);
        looping = (m == M_CBIDIR) || (m == M_RECIRC);
        return defined && !(looping && to_bb);
    endfunction

endpackage

// File: rtl/wseq_seg_bank.sv
module wseq_seg_bank
    import wseq_pkg::*;
#(
    parameter int NUM_SEG = 4,
    parameter int ADDR_W  = 10,
    parameter int RATE_W  = 16,
    localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEG_W-1:0]  widx,
    input  logic [ADDR_W-1:0] wstart,
    input  logic [ADDR_W-1:0] wend,
    input  logic [RATE_W-1:0] wrate,
    input  logic [MODE_W-1:0] wmode,
    input  logic [SEG_W-1:0]  ridx,
    output logic [ADDR_W-1:0] rstart,
    output logic [ADDR_W-1:0] rend,
    output logic [RATE_W-1:0] rrate,
    output logic [MODE_W-1:0] rmode
);

    logic [ADDR_W-1:0] start_q [NUM_SEG];
    logic [ADDR_W-1:0] end_q   [NUM_SEG];
    logic [RATE_W-1:0] rate_q  [NUM_SEG];
    logic [MODE_W-1:0] mode_q  [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        logic hit;
        assign hit = we && (widx == SEG_W'(g));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[g] <= '0;
                end_q[g]   <= '0;
                rate_q[g]  <= '0;
                mode_q[g]  <= '0;
            end else if (hit) begin
                start_q[g] <= wstart;
                end_q[g]   <= wend;
                rate_q[g]  <= wrate;
                mode_q[g]  <= wmode;
            end
        end
    end

    always_comb begin
        rstart = '0;
        rend   = '0;
        rrate  = '0;
        rmode  = '0;
        for (int k = 0; k < NUM_SEG; k++) begin
            if (ridx == SEG_W'(k)) begin
                rstart = start_q[k];
                rend   = end_q[k];
                rrate  = rate_q[k];
                rmode  = mode_q[k];
            end
        end
    end

endmodule

// File: rtl/wseq_core.sv
module wseq_core
    import wseq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              update_i,
    input  logic              sel_i,
    input  logic              dest_bb_i,
    input  logic [ADDR_W-1:0] seg_start_i,
    input  logic [ADDR_W-1:0] seg_end_i,
    input  logic [RATE_W-1:0] seg_rate_i,
    input  logic [MODE_W-1:0] seg_mode_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              step_o,
    output logic              err_o,
    output logic              trig_o,
    output logic [MODE_W-1:0] mode_o,
    output logic [ADDR_W-1:0] start_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [RATE_W-1:0] cnt;
        logic              run;
        logic              up;
        logic              ok;
        logic [MODE_W-1:0] mode;
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] last;
        logic [RATE_W-1:0] rate;
        logic              err;
        logic              step;
        logic              upd_prev;
        logic              sel_prev;
    } seq_t;

    seq_t seq_q, seq_d;

    logic              upd_rise, sel_edge, resume, load;
    logic [RATE_W-1:0] eff_rate, new_rate;

    always_comb begin
        seq_d      = seq_q;
        seq_d.step = 1'b0;

        upd_rise = update_i && !seq_q.upd_prev;
        sel_edge = sel_i ^ seq_q.sel_prev;
        resume   = sel_edge && !upd_rise && seq_q.ok && (seq_q.mode == M_BIDIR);
        load     = upd_rise || (sel_edge && !resume);

        seq_d.upd_prev = update_i;
        seq_d.sel_prev = sel_i;

        eff_rate = (seq_q.rate == '0) ? RATE_W'(1) : seq_q.rate;
        new_rate = (seg_rate_i == '0) ? RATE_W'(1) : seg_rate_i;

        if (load) begin
            seq_d.first = seg_start_i;
            seq_d.last  = seg_end_i;
            seq_d.rate  = seg_rate_i;
            seq_d.mode  = seg_mode_i;
            if (mode_allowed(seg_mode_i, dest_bb_i)) begin
                seq_d.ok   = 1'b1;
                seq_d.err  = 1'b0;
                seq_d.run  = 1'b1;
                seq_d.addr = seg_start_i;
                seq_d.cnt  = new_rate;
                seq_d.up   = (seg_mode_i == M_BIDIR) ? sel_i : 1'b1;
                seq_d.step = 1'b1;
            end else begin
                seq_d.ok  = 1'b0;
                seq_d.err = 1'b1;
                seq_d.run = 1'b0;
            end
        end else if (resume) begin
            seq_d.up  = sel_i;
            seq_d.run = 1'b1;
            seq_d.cnt = eff_rate;
        end else if (seq_q.run) begin
            if (seq_q.cnt <= RATE_W'(1)) begin
                seq_d.cnt = eff_rate;
                case (seq_q.mode)
                    M_RAMP: begin
                        if (seq_q.addr == seq_q.last) begin
                            seq_d.run = 1'b0;
                        end else begin
                            seq_d.addr = seq_q.addr + 1'b1;
                            seq_d.step = 1'b1;
                        end
                    end
                    M_BIDIR: begin
                        if (seq_q.up) begin
                            if (seq_q.addr == seq_q.last) begin
                                seq_d.run = 1'b0;
                            end else begin
                                seq_d.addr = seq_q.addr + 1'b1;
                                seq_d.step = 1'b1;
                            end
                        end else begin
                            if (seq_q.addr == seq_q.first) begin
                                seq_d.run = 1'b0;
                            end else begin
                                seq_d.addr = seq_q.addr - 1'b1;
                                seq_d.step = 1'b1;
                            end
                        end
                    end
                    M_CBIDIR: begin
                        if (seq_q.first != seq_q.last) begin
                            if (seq_q.up) begin
                                if (seq_q.addr == seq_q.last) begin
                                    seq_d.up   = 1'b0;
                                    seq_d.addr = seq_q.addr - 1'b1;
                                end else begin
                                    seq_d.addr = seq_q.addr + 1'b1;
                                end
                            end else begin
                                if (seq_q.addr == seq_q.first) begin
                                    seq_d.up   = 1'b1;
                                    seq_d.addr = seq_q.addr + 1'b1;
                                end else begin
                                    seq_d.addr = seq_q.addr - 1'b1;
                                end
                            end
                            seq_d.step = 1'b1;
                        end
                    end
                    M_RECIRC: begin
                        if (seq_q.addr == seq_q.last) begin
                            seq_d.addr = seq_q.first;
                        end else begin
                            seq_d.addr = seq_q.addr + 1'b1;
                        end
                        seq_d.step = 1'b1;
                    end
                    default: seq_d.run = 1'b0;
                endcase
            end else begin
                seq_d.cnt = seq_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign addr_o  = seq_q.addr;
    assign step_o  = seq_q.step;
    assign err_o   = seq_q.err;
    assign trig_o  = load || resume;
    assign mode_o  = seq_q.mode;
    assign start_o = seq_q.first;

endmodule

// File: rtl/wseq_ram.sv
module wseq_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic              rvalid_q, rvalid_d;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_d  = rdata_q;
        rvalid_d = re;
        if (re) begin
            rdata_d = mem[raddr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rdata_q  <= rdata_d;
            rvalid_q <= rvalid_d;
        end
    end

    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;

endmodule

// File: rtl/wseq_top.sv
module wseq_top
    import wseq_pkg::*;
#(
    parameter int NUM_SEG = 4,
    parameter int ADDR_W  = 10,
    parameter int RATE_W  = 16,
    parameter int DATA_W  = 32,
    localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEG_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W-1:0] cfg_end,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic [2:0]        cfg_mode,
    input  logic              ram_we,
    input  logic [ADDR_W-1:0] ram_waddr,
    input  logic [DATA_W-1:0] ram_wdata,
    input  logic [SEG_W-1:0]  seg_idx_i,
    input  logic              update_i,
    input  logic              sel_pin_i,
    input  logic              dest_bb_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [HALF_W-1:0] i_o,
    output logic [HALF_W-1:0] q_o,
    output logic              valid_o,
    output logic              err_o
);

    logic [ADDR_W-1:0] sel_start, sel_end, seq_start;
    logic [RATE_W-1:0] sel_rate;
    logic [MODE_W-1:0] sel_mode, seq_mode;
    logic              seq_step, seq_trig;
    logic [DATA_W-1:0] word;

    wseq_seg_bank #(.NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W), .RATE_W(RATE_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_we), .widx(cfg_idx), .wstart(cfg_start), .wend(cfg_end),
        .wrate(cfg_rate), .wmode(cfg_mode),
        .ridx(seg_idx_i), .rstart(sel_start), .rend(sel_end),
        .rrate(sel_rate), .rmode(sel_mode)
    );

    wseq_core #(.ADDR_W(ADDR_W), .RATE_W(RATE_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .update_i(update_i), .sel_i(sel_pin_i), .dest_bb_i(dest_bb_i),
        .seg_start_i(sel_start), .seg_end_i(sel_end),
        .seg_rate_i(sel_rate), .seg_mode_i(sel_mode),
        .addr_o(addr_o), .step_o(seq_step), .err_o(err_o),
        .trig_o(seq_trig), .mode_o(seq_mode), .start_o(seq_start)
    );

    wseq_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .re(seq_step), .raddr(addr_o),
        .rdata_o(word), .rvalid_o(valid_o)
    );

    assign i_o = word[DATA_W-1 -: HALF_W];
    assign q_o = word[HALF_W-1:0];

endmodule

// File: rtl/wseq_chk.sv
module wseq_chk
    import wseq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              valid,
    input logic              err,
    input logic              trig,
    input logic              step,
    input logic [MODE_W-1:0] mode,
    input logic [ADDR_W-1:0] start
);

    // R10: every address load or move yields a valid pulse one clock later
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> valid);

    // R10: no valid pulse without a preceding load or move
    p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> !valid);

    // R4: without a trigger, one-shot ramp only moves upward by one
    p_ramp_by_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(trig) && mode == M_RAMP && addr != $past(addr))
        |-> addr == ADDR_W'($past(addr) + 1'b1));

    // R8: a refused trigger freezes the address until the next trigger
    p_refused_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !$past(trig)) |-> addr == $past(addr));

    // R6: bouncing ramp moves by exactly one either way
    p_bounce_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(trig) && mode == M_CBIDIR && addr != $past(addr))
        |-> (addr == ADDR_W'($past(addr) + 1'b1) || addr == ADDR_W'($past(addr) - 1'b1)));

    // R7: looping ramp moves up by one or wraps to its first address
    p_loop_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(trig) && mode == M_RECIRC && addr != $past(addr))
        |-> (addr == ADDR_W'($past(addr) + 1'b1) || addr == start));

endmodule

bind wseq_top wseq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr_o), .valid(valid_o), .err(err_o),
    .trig(seq_trig), .step(seq_step), .mode(seq_mode), .start(seq_start)
);

// File: tb/sim_wseq_top.sv
module sim_wseq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [9:0]  cfg_start = '0, cfg_end = '0;
    logic [15:0] cfg_rate = '0;
    logic [2:0]  cfg_mode = '0;
    logic        ram_we = 1'b0;
    logic [9:0]  ram_waddr = '0;
    logic [31:0] ram_wdata = '0;
    logic [1:0]  seg_idx = '0;
    logic        update = 1'b0, sel_pin = 1'b0, dest_bb = 1'b0;
    logic [9:0]  addr_o;
    logic [15:0] i_o, q_o;
    logic        valid_o, err_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    wseq_top u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_start(cfg_start), .cfg_end(cfg_end),
        .cfg_rate(cfg_rate), .cfg_mode(cfg_mode),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .seg_idx_i(seg_idx), .update_i(update), .sel_pin_i(sel_pin), .dest_bb_i(dest_bb),
        .addr_o(addr_o), .i_o(i_o), .q_o(q_o), .valid_o(valid_o), .err_o(err_o)
    );

    // ---------------- behavioural reference model ----------------
    int mem [1024];
    int s_first [4], s_last [4], s_rate [4], s_mode [4];
    int m_addr, m_cnt, m_first, m_last, m_rate, m_mode, m_i, m_q;
    bit m_run, m_up, m_ok, m_err, m_step, m_valid, m_updp, m_selp;

    function automatic int word_of(int a);
        return (((a * 37 + 5) & 16'hFFFF) << 16) | ((a ^ 16'h3C3C) & 16'hFFFF);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_cnt = 0; m_first = 0; m_last = 0; m_rate = 0; m_mode = 0;
            m_i = 0; m_q = 0; m_run = 0; m_up = 0; m_ok = 0; m_err = 0;
            m_step = 0; m_valid = 0; m_updp = 0; m_selp = 0;
            for (int k = 0; k < 4; k++) begin
                s_first[k] = 0; s_last[k] = 0; s_rate[k] = 0; s_mode[k] = 0;
            end
        end else begin
            bit rise, edge_s, res, nstep;
            int eff;
            // memory read of previous address
            if (m_step) begin
                m_i = (mem[m_addr] >> 16) & 16'hFFFF;
                m_q = mem[m_addr] & 16'hFFFF;
            end
            m_valid = m_step;
            if (ram_we) mem[ram_waddr] = ram_wdata;
            // sequencer
            rise = update && !m_updp;
            edge_s = (sel_pin != m_selp);
            m_updp = update; m_selp = sel_pin;
            res = edge_s && !rise && m_ok && (m_mode == 2);
            nstep = 0;
            eff = (m_rate == 0) ? 1 : m_rate;
            if (rise || (edge_s && !res)) begin
                int s;
                bit bad;
                s = seg_idx;
                m_first = s_first[s]; m_last = s_last[s]; m_rate = s_rate[s]; m_mode = s_mode[s];
                bad = (m_mode < 1) || (m_mode > 4) || (dest_bb && m_mode >= 3);
                if (bad) begin
                    m_ok = 0; m_err = 1; m_run = 0;
                end else begin
                    m_ok = 1; m_err = 0; m_run = 1; m_addr = m_first;
                    m_cnt = (m_rate == 0) ? 1 : m_rate;
                    m_up = (m_mode == 2) ? sel_pin : 1'b1;
                    nstep = 1;
                end
            end else if (res) begin
                m_up = sel_pin; m_run = 1; m_cnt = eff;
            end else if (m_run) begin
                if (m_cnt <= 1) begin
                    m_cnt = eff;
                    if (m_mode == 1 || (m_mode == 2 && m_up)) begin
                        if (m_addr == m_last) m_run = 0;
                        else begin m_addr = (m_addr + 1) % 1024; nstep = 1; end
                    end else if (m_mode == 2) begin
                        if (m_addr == m_first) m_run = 0;
                        else begin m_addr = (m_addr + 1023) % 1024; nstep = 1; end
                    end else if (m_mode == 3) begin
                        if (m_first != m_last) begin
                            if (m_up && m_addr == m_last) m_up = 0;
                            else if (!m_up && m_addr == m_first) m_up = 1;
                            m_addr = m_up ? (m_addr + 1) % 1024 : (m_addr + 1023) % 1024;
                            nstep = 1;
                        end
                    end else begin
                        m_addr = (m_addr == m_last) ? m_first : (m_addr + 1) % 1024;
                        nstep = 1;
                    end
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            m_step = nstep;
            if (cfg_we) begin
                s_first[cfg_idx] = cfg_start; s_last[cfg_idx] = cfg_end;
                s_rate[cfg_idx] = cfg_rate; s_mode[cfg_idx] = cfg_mode;
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // every-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, "addr_o", int'(addr_o), m_addr);
            check(cur_req, "i_o", int'(i_o), m_i);
            check(cur_req, "q_o", int'(q_o), m_q);
            check(cur_req, "valid_o", int'(valid_o), int'(m_valid));
            check(cur_req, "err_o", int'(err_o), int'(m_err));
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_seg(int idx, int st, int en, int rt, int md);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 2'(idx); cfg_start = 10'(st); cfg_end = 10'(en);
        cfg_rate = 16'(rt); cfg_mode = 3'(md);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic pulse_update();
        @(negedge clk);
        update = 1;
        @(negedge clk);
        update = 0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog run did not end actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "addr_o in reset", int'(addr_o), 0);
        check("R1", "valid_o in reset", int'(valid_o), 0);
        check("R1", "err_o in reset", int'(err_o), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "i_o after reset", int'(i_o), 0);
        check("R1", "q_o after reset", int'(q_o), 0);

        // preload every memory word
        for (int a = 0; a < 1024; a++) begin
            ram_we = 1; ram_waddr = 10'(a); ram_wdata = 32'(word_of(a));
            @(negedge clk);
        end
        ram_we = 0;

        // R4 / R3 / R2: one-shot ramp 10..14 every 3 clocks
        cur_req = "R4";
        write_seg(0, 10, 14, 3, 1);
        seg_idx = 0;
        pulse_update();
        check("R2", "addr_o after update trigger", int'(addr_o), 10);
        cycles(2);
        check("R3", "addr_o before first interval", int'(addr_o), 10);
        @(negedge clk);
        check("R3", "addr_o after one interval", int'(addr_o), 11);
        cycles(30);
        check("R4", "addr_o held at last", int'(addr_o), 14);
        check("R10", "i_o upper half", int'(i_o), (word_of(14) >> 16) & 16'hFFFF);
        check("R10", "q_o lower half", int'(q_o), word_of(14) & 16'hFFFF);

        // R7: looping ramp 100..103, rate 0, triggered by a pin edge
        cur_req = "R7";
        write_seg(1, 100, 103, 0, 4);
        seg_idx = 1;
        @(negedge clk);
        sel_pin = 1;
        @(negedge clk);
        check("R2", "addr_o after pin trigger", int'(addr_o), 100);
        cycles(4);
        check("R7", "addr_o wrapped to first", int'(addr_o), 100);
        cycles(15);

        // R6: bouncing ramp 200..203, rate 1
        cur_req = "R6";
        write_seg(2, 200, 203, 1, 3);
        seg_idx = 2;
        pulse_update();
        cycles(4);
        check("R6", "addr_o after turn at last", int'(addr_o), 202);
        cycles(20);

        // R5: pin-steered ramp 300..305, rate 2, pin high -> up
        cur_req = "R5";
        write_seg(3, 300, 305, 2, 2);
        seg_idx = 3;
        pulse_update();
        cycles(20);
        check("R5", "addr_o stopped at last going up", int'(addr_o), 305);
        @(negedge clk);
        sel_pin = 0;
        @(negedge clk);
        check("R5", "pin edge does not reload", int'(addr_o), 305);
        cycles(30);
        check("R5", "addr_o stopped at first going down", int'(addr_o), 300);

        // R8: refused codes
        cur_req = "R8";
        write_seg(0, 500, 510, 1, 5);
        seg_idx = 0;
        pulse_update();
        check("R8", "err_o on code 101", int'(err_o), 1);
        cycles(5);
        check("R8", "addr_o held after refusal", int'(addr_o), 300);
        check("R8", "valid_o after refusal", int'(valid_o), 0);
        write_seg(0, 500, 510, 1, 0);
        pulse_update();
        check("R8", "err_o on code 000", int'(err_o), 1);
        cycles(3);

        // R9: baseband destination refuses looping codes only
        cur_req = "R9";
        dest_bb = 1;
        seg_idx = 1;
        pulse_update();
        check("R9", "err_o for looping code at baseband", int'(err_o), 1);
        cycles(3);
        write_seg(0, 600, 603, 1, 1);
        seg_idx = 0;
        pulse_update();
        check("R9", "err_o for one-shot at baseband", int'(err_o), 0);
        cycles(12);
        check("R9", "one-shot plays at baseband", int'(addr_o), 603);
        dest_bb = 0;

        // R11: rewrite active descriptor during playback
        cur_req = "R11";
        write_seg(0, 400, 420, 4, 1);
        pulse_update();
        cycles(10);
        write_seg(0, 700, 701, 1, 4);
        cycles(100);
        check("R11", "active ramp kept captured last", int'(addr_o), 420);
        pulse_update();
        check("R11", "new fields used at next trigger", int'(addr_o), 700);
        cycles(8);

        done = 1;
        summary();
        $finish;
    end

endmodule